// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a small 8-bit controller against runaway software. A free-running prescaler divides the clock by a ratio picked from a 3-bit code. Each time the prescaler completes a period, it advances a watchdog counter by one. When that counter rolls over from all ones, the block pulses a timeout output for one cycle. The system uses that pulse as its reset request.

Software keeps the system alive by writing the control register with the kick bit set. A kick zeroes both the prescaler and the watchdog counter. A second control bit decides whether counting continues while the CPU reports idle. When the block-level enable is low, all counting state is held at zero.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the readback `ctrlRdata` is 0x00. The readback shows the prescaler code in bits [2:0] and the idle-run bit in bit 4. All other bits read as 0.
- R2: The kick bit (bit 7 of a write) is never stored. `ctrlRdata[7]` reads 0 after any write, including one that sets it.
- R3: A write with bit 7 set zeroes the prescaler and the watchdog counter at that clock edge. The next timeout then needs a full 2^CNT_W prescaler periods, counted from the edge after the write.
- R4: Prescaler codes 0, 1, 2 and 3 give periods of 2, 8, 4 and 16 clocks respectively.
- R5: Prescaler codes 4, 5, 6 and 7 give periods of 32, 64, 128 and 256 clocks respectively.
- R6: Each prescaler period advances the watchdog counter by exactly one. Starting from zero, timeout follows the (2^CNT_W × ratio)-th counting clock edge.
- R7: Timeout is high for exactly one cycle when the counter wraps. Counting then carries on from zero, so the next timeout comes after another full interval.
- R8: With the idle-run bit at 0, every clock edge that sees `cpuIdle` high leaves both the prescaler and the counter unchanged.
- R9: With the idle-run bit at 1, `cpuIdle` has no effect on counting.
- R10: A new prescaler code written without a kick does not alter the period in progress. It takes effect from the next prescaler restart, which is a period end, a kick or a disable.
- R11: While `wdtEnable` is 0, the prescaler and counter are held at zero and timeout stays low. Re-enabling starts a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Write data: [2:0] prescaler code, [4] idle-run, [7] kick |
| wdtEnable | input | 1 | Watchdog enable; 0 holds all counting state at zero |
| cpuIdle | input | 1 | CPU idle-mode indicator |
| timeout | output | 1 | One-cycle reset request on counter wrap |
| ctrlRdata | output | 8 | Control register readback |

## Verification
The bench measures the exact edge count to timeout for all eight prescaler codes. A design that used a plain power-of-two ramp would swap the code 1 and code 2 intervals and land a factor of two off. Idle windows are counted both with and without the idle-run bit, so a design that ignored the bit, or froze counting when it should not, shifts the interval by exactly the window length. A code change in the middle of a period must keep the old 256-clock period before switching. An early switch would give a much shorter interval. Kicks, disables and the pulse width are checked for partial clearing, a held pulse, or a counter that fails to restart after a wrap.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Control register field positions (readback and write decode agree on these)
  localparam int KICK_BIT = 7;
  localparam int IDLE_BIT = 4;
  localparam int SEL_W    = 3;

  // Largest prescaler ratio is 256, so the prescaler counter needs 8 bits
  localparam int PRE_W    = 8;

  typedef struct packed {
    logic zero;     // hold everything at zero (watchdog disabled)
    logic restart;  // kick: restart prescaler and counter
    logic run;      // counting allowed this cycle
  } wdt_strobe_t;

  // Division ratio for a select code; codes 1 and 2 are deliberately swapped
  function automatic logic [PRE_W:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [PRE_W:0] r;
    case (code)
      3'd0: r = 9'd2;
      3'd1: r = 9'd8;
      3'd2: r = 9'd4;
      3'd3: r = 9'd16;
      3'd4: r = 9'd32;
      3'd5: r = 9'd64;
      3'd6: r = 9'd128;
      default: r = 9'd256;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlWdata,
  input  logic              wdtEnable,
  input  logic              cpuIdle,
  output wdt_strobe_t       strobe,
  output logic [SEL_W-1:0]  selNext,
  output logic [7:0]        ctrlRdata
);

  logic [SEL_W-1:0] selQ;
  logic             idleRunQ;
  logic             kickNow;
  logic             unusedBits;

  assign kickNow    = ctrlWe & ctrlWdata[KICK_BIT];
  assign unusedBits = ^{ctrlWdata[6:5], ctrlWdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ     <= '0;
      idleRunQ <= 1'b0;
    end else if (ctrlWe) begin
      selQ     <= ctrlWdata[SEL_W-1:0];
      idleRunQ <= ctrlWdata[IDLE_BIT];
    end
  end

  // Code seen by a restart in this cycle: a simultaneous write wins
  assign selNext = ctrlWe ? ctrlWdata[SEL_W-1:0] : selQ;

  always_comb begin
    strobe.zero    = ~wdtEnable;
    strobe.restart = kickNow;
    strobe.run     = wdtEnable & (~cpuIdle | idleRunQ);
  end

  always_comb begin
    ctrlRdata                = '0;
    ctrlRdata[SEL_W-1:0]     = selQ;
    ctrlRdata[IDLE_BIT]      = idleRunQ;
  end

endmodule

// File: rtl/wdt_guard_dp.sv
module wdt_guard_dp
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_strobe_t      strobe,
  input  logic [SEL_W-1:0] selNext,
  output logic             timeout,
  output logic [CNT_W-1:0] wdCount
);

  logic [SEL_W-1:0] activeSel;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   ratioM1;
  logic             preEnd;
  logic             preTick;
  logic             hold;

  assign hold    = strobe.zero | strobe.restart;
  assign ratioM1 = ratioOf(activeSel) - 1'b1;
  assign preEnd  = ({1'b0, preCnt} == ratioM1);
  assign preTick = strobe.run & ~hold & preEnd;

  // Prescaler: code is latched only at a restart, so a period is never cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt    <= '0;
      activeSel <= '0;
    end else if (hold || preTick) begin
      preCnt    <= '0;
      activeSel <= selNext;
    end else if (strobe.run) begin
      preCnt    <= preCnt + 1'b1;
    end
  end

  // Watchdog counter and one-cycle wrap pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdCount <= '0;
      timeout <= 1'b0;
    end else if (hold) begin
      wdCount <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= preTick & (&wdCount);
      if (preTick) wdCount <= wdCount + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  input  logic       wdtEnable,
  input  logic       cpuIdle,
  output logic       timeout,
  output logic [7:0] ctrlRdata
);

  wdt_strobe_t      strobe;
  logic [SEL_W-1:0] selNext;
  logic [CNT_W-1:0] wdCount;

  wdt_guard_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .wdtEnable (wdtEnable),
    .cpuIdle   (cpuIdle),
    .strobe    (strobe),
    .selNext   (selNext),
    .ctrlRdata (ctrlRdata)
  );

  wdt_guard_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .selNext (selNext),
    .timeout (timeout),
    .wdCount (wdCount)
  );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrlWe,
  input logic [7:0]       ctrlWdata,
  input logic             wdtEnable,
  input logic             cpuIdle,
  input logic             timeout,
  input logic [7:0]       ctrlRdata,
  input logic [CNT_W-1:0] wdCount
);

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wdtEnable |=> (!timeout && wdCount == '0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWe && ctrlWdata[7]) |=> (wdCount == '0 && !timeout));

  a_r2_kick_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWe && ctrlWdata[7]) |=> !ctrlRdata[7]);

  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wdtEnable && cpuIdle && !ctrlRdata[4] && !(ctrlWe && ctrlWdata[7]))
      |=> ($stable(wdCount) && !timeout));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wdCount) |-> (wdCount == $past(wdCount) + 1'b1 || wdCount == '0));

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrlWe    (ctrlWe),
  .ctrlWdata (ctrlWdata),
  .wdtEnable (wdtEnable),
  .cpuIdle   (cpuIdle),
  .timeout   (timeout),
  .ctrlRdata (ctrlRdata),
  .wdCount   (wdCount)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;

  localparam int CW   = 4;
  localparam int SPAN = 1 << CW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlWdata = 8'h00;
  logic       wdtEnable = 1'b0;
  logic       cpuIdle = 1'b0;
  logic       timeout;
  logic [7:0] ctrlRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  wdt_guard #(.CNT_W(CW)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .wdtEnable(wdtEnable), .cpuIdle(cpuIdle),
    .timeout(timeout), .ctrlRdata(ctrlRdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int code);
    case (code)
      0: return 2;   1: return 8;   2: return 4;   3: return 16;
      4: return 32;  5: return 64;  6: return 128; default: return 256;
    endcase
  endfunction

  // Called at a negedge; returns at a negedge
  task automatic wr(input logic [7:0] d);
    ctrlWe = 1'b1; ctrlWdata = d;
    @(posedge clk); @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  // Disable, set code and idle-run, leave disabled
  task automatic setup(input logic [7:0] d);
    wdtEnable = 1'b0;
    wr(d);
    @(negedge clk);
  endtask

  // Enable and count edges until timeout; optional idle window and mid-run write
  task automatic runUntil(input int exp, input int idleFrom, input int idleLen,
                          input int chgAt, input logic [7:0] chgData, input string req);
    int n = 0;
    bit seen = 0;
    wdtEnable = 1'b1;
    while (!seen && n < 6000) begin
      cpuIdle   = (n >= idleFrom) && (n < idleFrom + idleLen);
      ctrlWe    = (n == chgAt);
      ctrlWdata = chgData;
      @(posedge clk); n++;
      #1;
      if (timeout) seen = 1;
      @(negedge clk);
      ctrlWe = 1'b0;
    end
    cpuIdle = 1'b0;
    check(req, n, exp);
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset readback", ctrlRdata, 0);
    check("R11 reset timeout low", timeout, 0);
  endtask

  task automatic t_readback;
    setup(8'h93);
    check("R1 readback fields", ctrlRdata, 8'h13);
    check("R2 kick bit reads 0", ctrlRdata[7], 0);
    setup(8'h00);
    check("R1 readback cleared", ctrlRdata, 8'h00);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      setup(8'(c));
      runUntil(SPAN * ratio(c), 9999, 0, -1, 8'h00,
               (c < 4) ? "R4 code interval" : "R5 code interval");
    end
  endtask

  task automatic t_pulse;
    setup(8'h02);
    runUntil(SPAN * 4, 9999, 0, -1, 8'h00, "R6 first interval");
    @(posedge clk); #1;
    check("R7 pulse one cycle", timeout, 0);
    @(negedge clk);
    runUntil(SPAN * 4 - 1, 9999, 0, -1, 8'h00, "R7 counting resumes after wrap");
  endtask

  task automatic t_idle;
    setup(8'h00);
    runUntil(SPAN * 2 + 7, 5, 7, -1, 8'h00, "R8 idle freezes counting");
    setup(8'h10);
    runUntil(SPAN * 2, 5, 7, -1, 8'h10, "R9 idle-run keeps counting");
  endtask

  task automatic t_kick;
    setup(8'h00);
    runUntil(21 + SPAN * 2, 9999, 0, 20, 8'h80, "R3 kick restarts");
    setup(8'h00);
    runUntil(21 + SPAN * 8, 9999, 0, 20, 8'h81, "R3 kick with new code");
  endtask

  task automatic t_selchange;
    setup(8'h07);
    runUntil(256 + (SPAN - 1) * 2, 9999, 0, 10, 8'h00, "R10 code change deferred");
  endtask

  task automatic t_disable;
    int hits = 0;
    setup(8'h00);
    wdtEnable = 1'b1;
    repeat (20) @(negedge clk);
    wdtEnable = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (timeout) hits++;
    end
    check("R11 no timeout while disabled", hits, 0);
    @(negedge clk);
    runUntil(SPAN * 2, 9999, 0, -1, 8'h00, "R11 full interval after re-enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_readback();
    t_codes();
    t_pulse();
    t_idle();
    t_kick();
    t_selchange();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule